// File: doc/BRIEF.md
# Exception-Level Entry and Return Unit

This block performs register-based privilege transitions for a core that has numbered exception levels. It keeps a processor-state register, a saved-state register, an exception link register and a vector base register. While the core runs at level 0, it accepts four kinds of exception request: supervisor call, IRQ, FIQ and SError. When it takes one, it saves the current state, records where execution should resume, and raises the level to 1. It also reports the handler address, which is the vector base plus a fixed offset for each kind of exception.

An exception-return strobe reverses the transition in a single clock edge. The processor state is reloaded from the saved-state register and the program counter is redirected to the link register. Nothing is pushed to memory. The switch to the privileged stack is made only by setting the stack-select bit, because each level has its own stack pointer. Privileged code prepares the return state through a saved-state write port.

Top module: `el_entry_unit`

## Requirements
- R1: On the edge that takes an exception, the saved-state output receives the processor state held just before that edge, all seven bits at once.
- R2: For a supervisor call the link register receives the request-cycle PC plus 4.
- R3: After an entry the processor state equals 7'b01_1_1111. The state layout is [6:5] level, [4] stack select, [3] debug mask, [2] SError mask, [1] IRQ mask, [0] FIQ mask.
- R4: After an entry the next PC equals the vector base plus 0x400 for a supervisor call, 0x480 for IRQ, 0x500 for FIQ or 0x580 for SError. The vector base is loaded by vbar_we_i.
- R5: An exception return at a level other than 0 loads the processor state from the saved-state register and the next PC from the link register, on the same edge.
- R6: redirect_o is high for exactly the one cycle after an entry or return is taken. Exception requests at a level other than 0 are ignored, and so is a return strobe at level 0.
- R7: When several unmasked requests arrive together, the priority is SError, then FIQ, then IRQ, then supervisor call.
- R8: An IRQ request is ignored while mask bit [1] is set, an FIQ request while bit [0] is set, and an SError request while bit [2] is set. A supervisor call is never masked.
- R9: For IRQ, FIQ and SError the link register receives the request-cycle PC unchanged.
- R10: A saved-state write takes effect only at a level other than 0. At level 0 it leaves the saved-state output unchanged.
- R11: After reset the processor state, saved state, link register, next PC and redirect are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| svc_req_i | input | 1 | Supervisor call request |
| irq_req_i | input | 1 | IRQ request |
| fiq_req_i | input | 1 | FIQ request |
| serr_req_i | input | 1 | SError request |
| pc_i | input | ADDR_W | PC of the current instruction |
| eret_i | input | 1 | Exception return strobe |
| vbar_we_i | input | 1 | Vector base write enable |
| vbar_d_i | input | ADDR_W | Vector base write data |
| spsr_we_i | input | 1 | Saved-state write enable |
| spsr_d_i | input | 7 | Saved-state write data |
| redirect_o | output | 1 | next_pc_o has just been loaded |
| next_pc_o | output | ADDR_W | Handler or return address |
| pstate_o | output | 7 | Current processor state |
| spsr_o | output | 7 | Saved processor state |
| elr_o | output | ADDR_W | Exception link register |

## Verification
Every result of this block comes from a register. A request, return strobe or write applied before a rising edge therefore shows on the outputs right after that same edge: that is one cycle of latency for the state, link, PC and redirect. The bench drives inputs at the falling edge and samples 1 ns after the next rising edge. It then clears the inputs at the following falling edge, so each redirect pulse is seen exactly once. The sweep covers all sixteen request combinations under all sixteen mask settings. For each one, the expected kind, offset and link value are computed arithmetically in the bench.

// File: rtl/el_pkg.sv
package el_pkg;
  typedef struct packed {
    logic [1:0] lvl;
    logic       sp_sel;
    logic       dbg_m;
    logic       serr_m;
    logic       irq_m;
    logic       fiq_m;
  } pstate_t;

  // encoding order sets the vector slot: offset = base + kind * stride
  typedef enum logic [1:0] {
    EXC_SYNC = 2'd0,
    EXC_IRQ  = 2'd1,
    EXC_FIQ  = 2'd2,
    EXC_SERR = 2'd3
  } exc_kind_t;

  localparam int unsigned VEC_LOWER_OFF = 32'h400;
  localparam int unsigned VEC_STRIDE_SH = 7;
  localparam int unsigned PSTATE_W      = $bits(pstate_t);
endpackage

// File: rtl/el_req_arbiter.sv
module el_req_arbiter
  import el_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      svc_i,
  input  logic      irq_i,
  input  logic      fiq_i,
  input  logic      serr_i,
  input  logic      irq_m_i,
  input  logic      fiq_m_i,
  input  logic      serr_m_i,
  output logic      take_o,
  output exc_kind_t kind_o
);
  localparam int unsigned N_SRC = 4;

  logic [N_SRC-1:0] req_eff;
  logic [N_SRC-1:0] grant;

  // index = exc_kind_t encoding
  assign req_eff[EXC_SYNC] = svc_i;
  assign req_eff[EXC_IRQ]  = irq_i  & ~irq_m_i;
  assign req_eff[EXC_FIQ]  = fiq_i  & ~fiq_m_i;
  assign req_eff[EXC_SERR] = serr_i & ~serr_m_i;

  // highest index wins
  always_comb begin
    grant  = '0;
    kind_o = EXC_SYNC;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_eff[i]) begin
        grant     = '0;
        grant[i]  = en_i;
        kind_o    = exc_kind_t'(i);
      end
    end
  end

  assign take_o = |grant;

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant)); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_m_i |-> !grant[EXC_IRQ]); // R8
  AST_FIQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_m_i |-> !grant[EXC_FIQ]); // R8
  AST_SERR_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_m_i |-> !grant[EXC_SERR]); // R8
endmodule

// File: rtl/el_vector_gen.sv
module el_vector_gen
  import el_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] vbar_i,
  input  exc_kind_t         kind_i,
  output logic [ADDR_W-1:0] vec_o
);
  localparam logic [ADDR_W-1:0] LOWER_OFF = ADDR_W'(VEC_LOWER_OFF);

  logic [ADDR_W-1:0] slot_off;

  assign slot_off = ADDR_W'(kind_i) << VEC_STRIDE_SH;
  assign vec_o    = vbar_i + LOWER_OFF + slot_off;
endmodule

// File: rtl/el_entry_unit.sv
module el_entry_unit
  import el_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                svc_req_i,
  input  logic                irq_req_i,
  input  logic                fiq_req_i,
  input  logic                serr_req_i,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic                eret_i,
  input  logic                vbar_we_i,
  input  logic [ADDR_W-1:0]   vbar_d_i,
  input  logic                spsr_we_i,
  input  logic [PSTATE_W-1:0] spsr_d_i,
  output logic                redirect_o,
  output logic [ADDR_W-1:0]   next_pc_o,
  output logic [PSTATE_W-1:0] pstate_o,
  output logic [PSTATE_W-1:0] spsr_o,
  output logic [ADDR_W-1:0]   elr_o
);
  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

  pstate_t           pstate_q, spsr_q, entry_state;
  logic [ADDR_W-1:0] elr_q, vbar_q, next_pc_q, vec_addr, link_addr;
  logic              redirect_q;
  logic              at_user, exc_take, eret_take;
  exc_kind_t         exc_kind;

  assign at_user = (pstate_q.lvl == 2'd0);

  el_req_arbiter i_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (at_user),
    .svc_i    (svc_req_i),
    .irq_i    (irq_req_i),
    .fiq_i    (fiq_req_i),
    .serr_i   (serr_req_i),
    .irq_m_i  (pstate_q.irq_m),
    .fiq_m_i  (pstate_q.fiq_m),
    .serr_m_i (pstate_q.serr_m),
    .take_o   (exc_take),
    .kind_o   (exc_kind)
  );

  el_vector_gen #(.ADDR_W(ADDR_W)) i_vec (
    .vbar_i (vbar_q),
    .kind_i (exc_kind),
    .vec_o  (vec_addr)
  );

  assign eret_take = eret_i & ~at_user;
  // sync resumes after the call, async re-runs the interrupted insn
  assign link_addr = (exc_kind == EXC_SYNC) ? pc_i + INSN_BYTES : pc_i;

  always_comb begin
    entry_state        = '0;
    entry_state.lvl    = 2'd1;
    entry_state.sp_sel = 1'b1;
    entry_state.dbg_m  = 1'b1;
    entry_state.serr_m = 1'b1;
    entry_state.irq_m  = 1'b1;
    entry_state.fiq_m  = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pstate_q   <= '0;
      spsr_q     <= '0;
      elr_q      <= '0;
      vbar_q     <= '0;
      next_pc_q  <= '0;
      redirect_q <= 1'b0;
    end else begin
      redirect_q <= exc_take | eret_take;
      if (vbar_we_i) vbar_q <= vbar_d_i;
      if (exc_take) begin
        spsr_q    <= pstate_q;
        elr_q     <= link_addr;
        pstate_q  <= entry_state;
        next_pc_q <= vec_addr;
      end else if (eret_take) begin
        pstate_q  <= spsr_q;
        next_pc_q <= elr_q;
      end else if (spsr_we_i && !at_user) begin
        spsr_q <= spsr_d_i;
      end
    end
  end

  assign redirect_o = redirect_q;
  assign next_pc_o  = next_pc_q;
  assign pstate_o   = pstate_q;
  assign spsr_o     = spsr_q;
  assign elr_o      = elr_q;

  AST_SAVE_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_take |=> spsr_q == $past(pstate_q)); // R1
  AST_ENTRY_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_take |=> (pstate_q.lvl == 2'd1) && pstate_q.sp_sel && pstate_q.dbg_m
                 && pstate_q.serr_m && pstate_q.irq_m && pstate_q.fiq_m); // R3
  AST_ERET_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eret_take |=> (pstate_q == $past(spsr_q)) && (next_pc_q == $past(elr_q))); // R5
  AST_USER_ERET_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_user && eret_i && !exc_take) |=> !redirect_q && $stable(pstate_q)); // R6
  AST_PRIV_REQ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!at_user && !eret_i) |=> !redirect_q && $stable(pstate_q)); // R6
endmodule

// File: tb/test_el_entry_unit.sv
`timescale 1ns/1ps
module test_el_entry_unit;
  localparam int unsigned AW = 32;
  localparam logic [AW-1:0] VBAR = 32'h0001_2000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          svc = 0, irq = 0, fiq = 0, serr = 0, eret = 0, vbar_we = 0, spsr_we = 0;
  logic [AW-1:0] pc = '0, vbar_d = '0;
  logic [6:0]    spsr_d = '0;
  logic          redirect;
  logic [AW-1:0] next_pc, elr;
  logic [6:0]    pstate, spsr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  el_entry_unit #(.ADDR_W(AW)) i_el_entry_unit (
    .clk_i(clk), .rst_ni(rst_n), .svc_req_i(svc), .irq_req_i(irq), .fiq_req_i(fiq),
    .serr_req_i(serr), .pc_i(pc), .eret_i(eret), .vbar_we_i(vbar_we), .vbar_d_i(vbar_d),
    .spsr_we_i(spsr_we), .spsr_d_i(spsr_d), .redirect_o(redirect), .next_pc_o(next_pc),
    .pstate_o(pstate), .spsr_o(spsr), .elr_o(elr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inputs already driven at a falling edge; sample after the rising edge, then clear
  task automatic tick();
    @(posedge clk); #1;
  endtask
  task automatic clear();
    @(negedge clk);
    svc = 0; irq = 0; fiq = 0; serr = 0; eret = 0; vbar_we = 0; spsr_we = 0;
  endtask

  // from level 1, return to level 0 with mask set m (R5, R10)
  task automatic drop_to_user(input logic [3:0] m, input logic [AW-1:0] exp_ret);
    spsr_we = 1; spsr_d = {2'b00, 1'b0, m};
    tick(); check("R10 spsr write at level 1", spsr, {2'b00, 1'b0, m}); clear();
    eret = 1;
    tick();
    check("R5 eret state", pstate, {2'b00, 1'b0, m});
    check("R5 eret pc", next_pc, exp_ret);
    check("R6 eret redirect", redirect, 1'b1);
    clear();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] p;
    logic [1:0]    kind;
    logic          hit;
    bit            at_el1;
    repeat (2) @(negedge clk);
    check("R11 reset pstate", pstate, 7'h00);
    check("R11 reset spsr", spsr, 7'h00);
    check("R11 reset elr", elr, '0);
    check("R11 reset next_pc", next_pc, '0);
    check("R11 reset redirect", redirect, 1'b0);
    rst_n = 1;
    @(negedge clk);
    vbar_we = 1; vbar_d = VBAR; tick(); clear();

    // R10: write ignored at level 0
    spsr_we = 1; spsr_d = 7'h55;
    tick(); check("R10 spsr write ignored at level 0", spsr, 7'h00); clear();
    // R6: return strobe at level 0 ignored
    eret = 1;
    tick();
    check("R6 eret at level 0 redirect", redirect, 1'b0);
    check("R6 eret at level 0 state", pstate, 7'h00);
    clear();

    at_el1 = 0;
    for (int m = 0; m < 16; m++) begin
      for (int r = 0; r < 16; r++) begin
        if (!at_el1) begin
          p = 32'h4000_0000 + AW'(m * 256 + r * 16);
          svc = 1; pc = p; tick(); clear();
        end
        drop_to_user(m[3:0], at_el1 ? elr : p + 4);
        at_el1 = 0;
        p = 32'h1000_0000 + AW'(m * 256 + r * 16);
        hit = 1'b1;
        if (r[3] && !m[2])      kind = 2'd3;
        else if (r[2] && !m[0]) kind = 2'd2;
        else if (r[1] && !m[1]) kind = 2'd1;
        else if (r[0])          kind = 2'd0;
        else begin kind = 2'd0; hit = 1'b0; end
        svc = r[0]; irq = r[1]; fiq = r[2]; serr = r[3]; pc = p;
        tick();
        check("R6/R8 redirect", redirect, hit);
        if (hit) begin
          check("R4/R7 vector", next_pc, VBAR + 32'h400 + AW'(kind) * 32'h80);
          check(kind == 0 ? "R2 svc link" : "R9 async link", elr, kind == 0 ? p + 4 : p);
          check("R1 saved state", spsr, {2'b00, 1'b0, m[3:0]});
          check("R3 entry state", pstate, 7'b01_1_1111);
          at_el1 = 1;
        end else begin
          check("R8 masked state kept", pstate, {2'b00, 1'b0, m[3:0]});
        end
        clear();
        if (at_el1) begin
          tick(); check("R6 redirect one cycle", redirect, 1'b0);
        end
      end
    end

    // R6: requests at level 1 ignored (now at level 1 or go there)
    if (!at_el1) begin svc = 1; pc = 32'h20; tick(); clear(); end
    serr = 1; irq = 1; fiq = 1; svc = 1; pc = 32'h7777_0000;
    tick();
    check("R6 level 1 requests redirect", redirect, 1'b0);
    check("R6 level 1 requests state", pstate, 7'b01_1_1111);
    clear();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule